// File: doc/BRIEF.md
# Instruction Word Prefetch Pipe

This block is a short queue of 16-bit instruction words that sits between the instruction fetch path and the opcode decoder. A 32-bit holding register takes in one long word at a time, together with a flag that says whether the fetch that produced it ended abnormally, for example with a bus error. The fetch can come from the instruction cache or from an external access.

Each prefetch request takes one half of the holding register and pushes it into the entry stage. At the same time it moves every older word one stage toward the exit. Only the exit stage faces the decoder. A word that carries an abnormal-fetch tag is reported on a fault output and is never offered as a decodable word. Nothing moves unless a request is accepted.

The prefetch interface is a valid/ready pair. A request is taken on a rising clock edge where `pf_req` and `pf_rdy` are both high. While `pf_rdy` is low, the requester holds `pf_req` and `pf_addr1` steady and waits. Nothing is dropped silently: a request is either accepted or still pending. The decoder side has no back-pressure. It sees the exit stage at all times, and that stage changes only when a request is accepted or when the pipe is flushed.

Top module: `insn_word_pipe`

## Requirements
- R1: After reset, all three stages are empty, `dec_valid` and `dec_fault` are low, and `pf_rdy` is low.
- R2: `pf_rdy` is high exactly when the holding register has been loaded at least once since reset and `flush` is low. A request is accepted on a rising edge where `pf_req` and `pf_rdy` are both high.
- R3: A request made before any holding-register load stalls with `pf_rdy` low. It is accepted on the first edge after the edge that captures `hold_ld`.
- R4: An accepted request loads the selected word into the entry stage, moves the entry word to the middle stage and moves the middle word to the exit stage. A word reaches the decoder outputs after the third accepted request that counts from its own.
- R5: `pf_addr1` = 0 selects bits [31:16] of the holding register and `pf_addr1` = 1 selects bits [15:0]. Successive requests reuse the same long word until the next `hold_ld`. A request accepted in the same cycle as `hold_ld` still uses the previous contents.
- R6: `hold_fault` is captured together with the long word, and every word taken from that long word carries it. When the exit stage holds a tagged word, `dec_fault` is 1 and `dec_valid` is 0.
- R7: In a cycle without an accepted request, and without flush, no stage changes. This holds even when `hold_ld` loads new data in that cycle.
- R8: `flush` empties all three stages and clears all tags in one cycle. While `flush` is high, `pf_rdy` is low, so a request made in the same cycle is not taken.
- R9: `dec_word` shows the exit-stage word. `dec_valid` is 1 only when that stage holds an untagged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_ld | input | 1 | Load strobe for the holding register |
| hold_data | input | 32 | Long word from the cache or external fetch |
| hold_fault | input | 1 | Fetch of this long word ended abnormally |
| pf_req | input | 1 | Prefetch request (valid) |
| pf_addr1 | input | 1 | Word address bit 1: 0 = upper half, 1 = lower half |
| pf_rdy | output | 1 | Prefetch ready; low while stalled or flushing |
| flush | input | 1 | Synchronous flush of all stages |
| dec_valid | output | 1 | Exit stage holds a decodable word |
| dec_fault | output | 1 | Exit stage holds a word from an aborted fetch |
| dec_word | output | 16 | Exit-stage word |

## Verification
If a stage register is wrong, the decoder ports show it on a delay. A word that is dropped, duplicated or swapped shows up only when it reaches the exit stage, which is two accepted requests after it goes wrong. The scoreboard therefore compares every word, tag and valid flag as it leaves the pipe.

A half-select or tag-capture mistake stays hidden until the affected word reaches the exit. An unwanted shift on an idle cycle changes `dec_word` at once. A broken ready or flush path shows on `pf_rdy` in the same cycle.

// File: rtl/iwp_pkg.sv
package iwp_pkg;
  localparam int WORD_W = 16;
  localparam int LONG_W = 2 * WORD_W;

  typedef struct packed {
    logic              vld;
    logic              flt;
    logic [WORD_W-1:0] w;
  } slot_t;

  localparam slot_t SLOT_EMPTY = '0;
endpackage

// File: rtl/iwp_hold.sv
module iwp_hold
  import iwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [LONG_W-1:0] din,
  input  logic              fin,
  input  logic              sel_lo,
  output logic              hv,
  output slot_t             word_o
);
  localparam int HALVES = LONG_W / WORD_W;

  logic [LONG_W-1:0] long_q;
  logic              flt_q;
  logic [WORD_W-1:0] half [HALVES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      long_q <= '0;
      flt_q  <= 1'b0;
      hv     <= 1'b0;
    end else if (ld) begin
      long_q <= din;
      flt_q  <= fin;
      hv     <= 1'b1;
    end
  end

  // half[0] is the upper (earlier) word in big-endian order
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign half[h] = long_q[LONG_W-1-h*WORD_W -: WORD_W];
  end

  always_comb begin
    word_o     = SLOT_EMPTY;
    word_o.vld = 1'b1;
    word_o.flt = flt_q;
    word_o.w   = half[sel_lo];
  end

  // R3
  hold_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hv) |-> $past(ld));
endmodule

// File: rtl/iwp_stage.sv
module iwp_stage
  import iwp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  shift,
  input  slot_t d,
  output slot_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= SLOT_EMPTY;
    else if (shift)    q <= d;
  end

  // R7
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !clr) |=> $stable(q));

  // R8
  stage_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!q.vld && !q.flt));
endmodule

// File: rtl/insn_word_pipe.sv
module insn_word_pipe
  import iwp_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_ld,
  input  logic [LONG_W-1:0] hold_data,
  input  logic              hold_fault,
  input  logic              pf_req,
  input  logic              pf_addr1,
  output logic              pf_rdy,
  input  logic              flush,
  output logic              dec_valid,
  output logic              dec_fault,
  output logic [WORD_W-1:0] dec_word
);
  localparam int LAST = STAGES - 1;

  logic  hv;
  logic  acc;
  slot_t fresh;
  slot_t st_d [STAGES];
  slot_t st_q [STAGES];

  iwp_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (hold_ld),
    .din    (hold_data),
    .fin    (hold_fault),
    .sel_lo (pf_addr1),
    .hv     (hv),
    .word_o (fresh)
  );

  assign pf_rdy = hv & ~flush;
  assign acc    = pf_req & pf_rdy;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_entry
      assign st_d[i] = fresh;
    end else begin : g_inner
      assign st_d[i] = st_q[i-1];
      // R4
      shift_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> st_q[i] == $past(st_q[i-1]));
    end
    iwp_stage u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (flush),
      .shift (acc),
      .d     (st_d[i]),
      .q     (st_q[i])
    );
  end

  assign dec_word  = st_q[LAST].w;
  assign dec_valid = st_q[LAST].vld & ~st_q[LAST].flt;
  assign dec_fault = st_q[LAST].vld &  st_q[LAST].flt;

  // R6
  entry_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (st_q[0].vld && st_q[0].flt == $past(fresh.flt)));

  // R8
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !pf_rdy);
endmodule

// File: tb/insn_word_pipe_tb.sv
module insn_word_pipe_tb;
  typedef struct packed {
    logic        f;
    logic [15:0] w;
  } ex_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold_ld = 1'b0;
  logic [31:0] hold_data = '0;
  logic        hold_fault = 1'b0;
  logic        pf_req = 1'b0;
  logic        pf_addr1 = 1'b0;
  logic        pf_rdy;
  logic        flush = 1'b0;
  logic        dec_valid;
  logic        dec_fault;
  logic [15:0] dec_word;

  int   total = 0;
  int   bad = 0;
  ex_t  exp_q[$];
  bit   pend = 1'b0;
  logic [31:0] cur_long = '0;
  logic        cur_flt = 1'b0;

  always #10 clk = ~clk;

  insn_word_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .hold_ld(hold_ld), .hold_data(hold_data),
    .hold_fault(hold_fault), .pf_req(pf_req), .pf_addr1(pf_addr1),
    .pf_rdy(pf_rdy), .flush(flush), .dec_valid(dec_valid),
    .dec_fault(dec_fault), .dec_word(dec_word)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic load_long(input logic [31:0] d, input logic f);
    @(negedge clk);
    hold_ld = 1'b1; hold_data = d; hold_fault = f;
    @(negedge clk);
    hold_ld = 1'b0;
    cur_long = d; cur_flt = f;
  endtask

  task automatic push_exp(input logic a1);
    ex_t e;
    e.f = cur_flt;
    e.w = a1 ? cur_long[15:0] : cur_long[31:16];
    exp_q.push_back(e);
    pend = 1'b1;
  endtask

  task automatic prefetch(input logic a1);
    @(negedge clk);
    pf_req = 1'b1; pf_addr1 = a1;
    while (!pf_rdy) @(negedge clk);
    @(posedge clk);
    push_exp(a1);
    @(negedge clk);
    pf_req = 1'b0;
  endtask

  // monitor: the oldest word reaches the exit on the third accepted request
  always @(negedge clk) begin
    if (pend) begin
      pend = 1'b0;
      if (exp_q.size() == 3) begin
        ex_t e;
        e = exp_q.pop_front();
        check(dec_word == e.w, "R4 R5 R9 word", {16'h0, dec_word}, {16'h0, e.w});
        check(dec_fault == e.f, "R6 fault", {31'h0, dec_fault}, {31'h0, e.f});
        check(dec_valid == !e.f, "R6 R9 valid", {31'h0, dec_valid}, {31'h0, !e.f});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(pf_rdy == 1'b0, "R1 pf_rdy", {31'h0, pf_rdy}, 0);
    check(dec_valid == 1'b0, "R1 dec_valid", {31'h0, dec_valid}, 0);
    check(dec_fault == 1'b0, "R1 dec_fault", {31'h0, dec_fault}, 0);
    rst_n = 1'b1;

    // R3 stall before any load
    @(negedge clk);
    pf_req = 1'b1; pf_addr1 = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(pf_rdy == 1'b0, "R3 stall", {31'h0, pf_rdy}, 0);
    end
    check(dec_valid == 1'b0, "R3 no shift", {31'h0, dec_valid}, 0);
    hold_ld = 1'b1; hold_data = 32'hA1B2_C3D4; hold_fault = 1'b0;
    cur_long = 32'hA1B2_C3D4; cur_flt = 1'b0;
    @(negedge clk);
    hold_ld = 1'b0;
    check(pf_rdy == 1'b1, "R2 R3 ready after load", {31'h0, pf_rdy}, 1);
    @(posedge clk);
    push_exp(1'b0);
    @(negedge clk);
    pf_req = 1'b0;

    // R5 second half without reload, then a new long word
    prefetch(1'b1);
    load_long(32'h1122_3344, 1'b0);
    prefetch(1'b0);
    prefetch(1'b1);

    // R7 idle cycles with a holding-register load
    @(negedge clk);
    hold_ld = 1'b1; hold_data = 32'h5566_7788; hold_fault = 1'b1;
    cur_long = 32'h5566_7788; cur_flt = 1'b1;
    @(negedge clk);
    hold_ld = 1'b0;
    repeat (3) @(negedge clk);
    check(dec_word == 16'hC3D4, "R7 idle word", {16'h0, dec_word}, 32'hC3D4);
    check(dec_valid == 1'b1, "R7 idle valid", {31'h0, dec_valid}, 1);

    // R6 tagged words pass through to the exit
    prefetch(1'b0);
    prefetch(1'b1);
    load_long(32'h9900_AABB, 1'b0);
    prefetch(1'b0);
    prefetch(1'b1);
    prefetch(1'b0);

    // R8 flush with a concurrent request
    @(negedge clk);
    flush = 1'b1; pf_req = 1'b1; pf_addr1 = 1'b0;
    #1;
    check(pf_rdy == 1'b0, "R8 ready low in flush", {31'h0, pf_rdy}, 0);
    @(negedge clk);
    flush = 1'b0; pf_req = 1'b0;
    exp_q.delete();
    check(dec_valid == 1'b0, "R8 flushed valid", {31'h0, dec_valid}, 0);
    check(dec_fault == 1'b0, "R8 flushed fault", {31'h0, dec_fault}, 0);
    prefetch(1'b1);
    prefetch(1'b0);
    check(dec_valid == 1'b0, "R8 request dropped", {31'h0, dec_valid}, 0);
    prefetch(1'b1);
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule